// File: doc/BRIEF.md
# Exception Arbiter and Entry Sequencer

This block sits next to a small processor core. Seven kinds of exception request reach it: a reset request, a data abort, a prefetch abort, two active-low interrupt pins (fast and normal), and two decode flags from the execute stage, one for a software-interrupt instruction and one for an undefined instruction. The core also supplies its current status word and program counter. A fixed priority network picks one winner. Interrupt requests only compete while their disable bit in the supplied status word is clear. A short state machine then runs the entry steps in a fixed order. First the status word is copied into the saved-status register of the target mode. Next the return address goes into that mode's link register. Then the core is told to load the new status word. Last, it is told to load the handler vector as its next PC.

The block holds one banked saved-status register and one banked link register for each exception mode. It shows the pair that belongs to the mode in the supplied status word. A return request restores the status word from that saved copy and the PC from that link register, both in the same cycle.

State machine: `ST_IDLE` (arbitrate; serve a return), `ST_SAVE` (write saved status), `ST_LINK` (write link), `ST_MODE` (present new status), `ST_VECTOR` (present vector PC). Transitions: `ST_IDLE`→`ST_SAVE` when a winner exists; otherwise it stays in `ST_IDLE`. From there the steps go `ST_SAVE`→`ST_LINK`→`ST_MODE`→`ST_VECTOR`→`ST_IDLE`, each taking one cycle and having no condition.

Status word layout: bits [4:0] hold the mode. Bit 6 is the fast-interrupt disable and bit 7 is the interrupt disable. All other bits pass through unchanged.

Top module: `exc_entry`

## Requirements
- R1: In `ST_IDLE` the winner is picked in this order, from highest to lowest: reset request, data abort, fast interrupt, normal interrupt, prefetch abort, then software interrupt and undefined instruction together on the lowest level.
- R2: Handler vectors (PC values) are: reset 0x00, undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, normal interrupt 0x18, fast interrupt 0x1C.
- R3: If a request is present at the edge that leaves `ST_IDLE`, `status_load` is high with the new status two cycles later. `pc_load` is high with the vector in the cycle after that. `busy` is low again one cycle after that.
- R4: Every entry sets bit 7. Fast-interrupt entry and reset entry also set bit 6. Every other bit of the new status equals the status word sampled at arbitration, apart from the mode field.
- R5: Data abort entry leaves bit 6 as it was, so a fast interrupt raised during the data-abort handler is taken.
- R6: A fast interrupt competes only while bit 6 is 0. A normal interrupt competes only while bit 7 is 0. A masked request never starts an entry.
- R7: A reset request is taken whatever the values of bits 6 and 7.
- R8: Target modes are: fast interrupt 0x11, normal interrupt 0x12, reset and software interrupt 0x13 (supervisor), both aborts 0x17, undefined 0x1B.
- R9: `saved_status` and `link` show the banked pair of the mode in `cur_status[4:0]`. After entry they hold the sampled status and PC. They read 0 after reset and for modes 0x10 and 0x1F, which have no bank.
- R10: In `ST_IDLE`, with no winner, a return request in a banked mode raises `status_load` and `pc_load` in the same cycle, with `status_next` equal to the saved copy and `pc_next` equal to the link value.
- R11: A return request has no effect in mode 0x10 or 0x1F, and no effect while an exception wins arbitration; in that case the exception is entered instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low block reset |
| rst_req | input | 1 | Reset exception request |
| dabort | input | 1 | Data abort request |
| pabort | input | 1 | Prefetch abort request |
| fiq_n | input | 1 | Fast interrupt pin, active low |
| irq_n | input | 1 | Normal interrupt pin, active low |
| swi_dec | input | 1 | Software-interrupt instruction in execute |
| undef_dec | input | 1 | Undefined instruction in execute |
| ret_req | input | 1 | Return-from-exception request |
| cur_status | input | XLEN | Core's current status word |
| cur_pc | input | XLEN | Return address to save |
| busy | output | 1 | Entry sequence in progress |
| status_load | output | 1 | Core must load `status_next` |
| status_next | output | XLEN | New status word |
| pc_load | output | 1 | Core must load `pc_next` |
| pc_next | output | XLEN | Vector or return address |
| saved_status | output | XLEN | Saved status of the current mode |
| link | output | XLEN | Link value of the current mode |

## Verification
Each request is first driven alone from a fully unmasked status word, which isolates its vector, target mode and disable bits. Pairs and triples of requests then show the priority order: data abort against both interrupts, fast against normal interrupt plus prefetch abort, normal interrupt against both lower levels. Status words with bit 6 or bit 7 set show that a masked request passes priority to the next source, while reset still wins. A data-abort entry followed by a fast interrupt shows that the abort leaves that interrupt open. Return requests are tried in a banked mode, in an unbanked mode, and against a pending software interrupt, which separates the restore path from the cases where the request is ignored.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam logic [4:0] M_USR = 5'h10;
    localparam logic [4:0] M_FIQ = 5'h11;
    localparam logic [4:0] M_IRQ = 5'h12;
    localparam logic [4:0] M_SVC = 5'h13;
    localparam logic [4:0] M_ABT = 5'h17;
    localparam logic [4:0] M_UND = 5'h1B;
    localparam logic [4:0] M_SYS = 5'h1F;

    localparam int BIT_F    = 6;
    localparam int BIT_I    = 7;
    localparam int NBANK    = 5;
    localparam int BANK_IW  = $clog2(NBANK);

    typedef enum logic [2:0] {
        EX_NONE, EX_RESET, EX_DABT, EX_FIQ, EX_IRQ, EX_PABT, EX_SWI, EX_UND
    } exc_e;

    typedef struct packed {
        logic rst;
        logic dabt;
        logic fiq;
        logic irq;
        logic pabt;
        logic swi;
        logic und;
    } req_t;

    function automatic logic [4:0] target_mode(input exc_e k);
        unique case (k)
            EX_FIQ:          return M_FIQ;
            EX_IRQ:          return M_IRQ;
            EX_DABT, EX_PABT: return M_ABT;
            EX_UND:          return M_UND;
            default:         return M_SVC;
        endcase
    endfunction

    function automatic logic [7:0] vec_off(input exc_e k);
        unique case (k)
            EX_UND:  return 8'h04;
            EX_SWI:  return 8'h08;
            EX_PABT: return 8'h0C;
            EX_DABT: return 8'h10;
            EX_IRQ:  return 8'h18;
            EX_FIQ:  return 8'h1C;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic sets_f(input exc_e k);
        return (k == EX_FIQ) || (k == EX_RESET);
    endfunction

    function automatic logic [BANK_IW-1:0] bank_of(input logic [4:0] m);
        unique case (m)
            M_FIQ:   return BANK_IW'(0);
            M_IRQ:   return BANK_IW'(1);
            M_SVC:   return BANK_IW'(2);
            M_ABT:   return BANK_IW'(3);
            default: return BANK_IW'(4);
        endcase
    endfunction

    function automatic logic has_bank(input logic [4:0] m);
        return (m == M_FIQ) || (m == M_IRQ) || (m == M_SVC) ||
               (m == M_ABT) || (m == M_UND);
    endfunction

endpackage

// File: rtl/exc_prio.sv
module exc_prio
    import exc_pkg::*;
(
    input  req_t req,
    input  logic i_dis,
    input  logic f_dis,
    output exc_e win
);

    always_comb begin
        win = EX_NONE;
        if (req.rst)                  win = EX_RESET;
        else if (req.dabt)            win = EX_DABT;
        else if (req.fiq && !f_dis)   win = EX_FIQ;
        else if (req.irq && !i_dis)   win = EX_IRQ;
        else if (req.pabt)            win = EX_PABT;
        else if (req.swi)             win = EX_SWI;
        else if (req.und)             win = EX_UND;
    end

endmodule

// File: rtl/exc_bank.sv
module exc_bank
    import exc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sv_we,
    input  logic               lr_we,
    input  logic [BANK_IW-1:0] wr_idx,
    input  logic [XLEN-1:0]    sv_wdata,
    input  logic [XLEN-1:0]    lr_wdata,
    input  logic [BANK_IW-1:0] rd_idx,
    input  logic               rd_ok,
    output logic [XLEN-1:0]    sv_rdata,
    output logic [XLEN-1:0]    lr_rdata
);

    logic [XLEN-1:0] sv_mem [NBANK];
    logic [XLEN-1:0] lr_mem [NBANK];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sv_mem[b] <= '0;
                lr_mem[b] <= '0;
            end else begin
                if (sv_we && wr_idx == BANK_IW'(b)) sv_mem[b] <= sv_wdata;
                if (lr_we && wr_idx == BANK_IW'(b)) lr_mem[b] <= lr_wdata;
            end
        end
    end

    always_comb begin
        sv_rdata = '0;
        lr_rdata = '0;
        if (rd_ok && int'(rd_idx) < NBANK) begin
            sv_rdata = sv_mem[rd_idx];
            lr_rdata = lr_mem[rd_idx];
        end
    end

endmodule

// File: rtl/exc_entry.sv
module exc_entry
    import exc_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] VEC_BASE = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rst_req,
    input  logic            dabort,
    input  logic            pabort,
    input  logic            fiq_n,
    input  logic            irq_n,
    input  logic            swi_dec,
    input  logic            undef_dec,
    input  logic            ret_req,
    input  logic [XLEN-1:0] cur_status,
    input  logic [XLEN-1:0] cur_pc,
    output logic            busy,
    output logic            status_load,
    output logic [XLEN-1:0] status_next,
    output logic            pc_load,
    output logic [XLEN-1:0] pc_next,
    output logic [XLEN-1:0] saved_status,
    output logic [XLEN-1:0] link
);

    typedef enum logic [2:0] {
        ST_IDLE, ST_SAVE, ST_LINK, ST_MODE, ST_VECTOR
    } state_e;

    state_e          state_q, state_d;
    exc_e            win, win_q;
    logic [XLEN-1:0] stat_q, pc_q;
    logic [XLEN-1:0] entry_stat;
    logic            ret_ok;
    req_t            req;

    assign req = '{rst: rst_req, dabt: dabort, fiq: !fiq_n, irq: !irq_n,
                   pabt: pabort, swi: swi_dec, und: undef_dec};

    exc_prio u_prio (
        .req   (req),
        .i_dis (cur_status[BIT_I]),
        .f_dis (cur_status[BIT_F]),
        .win   (win)
    );

    exc_bank #(.XLEN(XLEN)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .sv_we    (state_q == ST_SAVE),
        .lr_we    (state_q == ST_LINK),
        .wr_idx   (bank_of(target_mode(win_q))),
        .sv_wdata (stat_q),
        .lr_wdata (pc_q),
        .rd_idx   (bank_of(cur_status[4:0])),
        .rd_ok    (has_bank(cur_status[4:0])),
        .sv_rdata (saved_status),
        .lr_rdata (link)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (win != EX_NONE) state_d = ST_SAVE;
            ST_SAVE:   state_d = ST_LINK;
            ST_LINK:   state_d = ST_MODE;
            ST_MODE:   state_d = ST_VECTOR;
            ST_VECTOR: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // capture of the winner and the context it interrupts
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q  <= EX_NONE;
            stat_q <= '0;
            pc_q   <= '0;
        end else if (state_q == ST_IDLE && win != EX_NONE) begin
            win_q  <= win;
            stat_q <= cur_status;
            pc_q   <= cur_pc;
        end
    end

    always_comb begin
        entry_stat        = stat_q;
        entry_stat[4:0]   = target_mode(win_q);
        entry_stat[BIT_I] = 1'b1;
        entry_stat[BIT_F] = stat_q[BIT_F] | sets_f(win_q);
    end

    assign ret_ok = (state_q == ST_IDLE) && ret_req && (win == EX_NONE) &&
                    has_bank(cur_status[4:0]);

    // outputs
    always_comb begin
        busy        = 1'b1;
        status_load = 1'b0;
        status_next = '0;
        pc_load     = 1'b0;
        pc_next     = '0;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
                if (ret_ok) begin
                    status_load = 1'b1;
                    status_next = saved_status;
                    pc_load     = 1'b1;
                    pc_next     = link;
                end
            end
            ST_MODE: begin
                status_load = 1'b1;
                status_next = entry_stat;
            end
            ST_VECTOR: begin
                pc_load = 1'b1;
                pc_next = VEC_BASE + XLEN'(vec_off(win_q));
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
    import exc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            rst_req,
    input logic            dabort,
    input logic            pabort,
    input logic            fiq_n,
    input logic            irq_n,
    input logic            swi_dec,
    input logic            undef_dec,
    input logic            ret_req,
    input logic [XLEN-1:0] cur_status,
    input logic            busy,
    input logic            status_load,
    input logic [XLEN-1:0] status_next,
    input logic            pc_load,
    input logic [XLEN-1:0] pc_next,
    input logic [XLEN-1:0] saved_status,
    input logic [XLEN-1:0] link
);

    logic fiq_live, irq_live, pending, banked, unbanked;
    assign fiq_live = !fiq_n && !cur_status[BIT_F];
    assign irq_live = !irq_n && !cur_status[BIT_I];
    assign pending  = rst_req || dabort || fiq_live || irq_live ||
                      pabort || swi_dec || undef_dec;
    assign banked   = cur_status[4:0] inside {M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND};
    assign unbanked = cur_status[4:0] inside {M_USR, M_SYS};

    p_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy && status_load |=> busy && pc_load && !status_load);

    p_reset_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && rst_req |=> busy);

    p_fiq_masks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy && status_load && status_next[4:0] == M_FIQ
        |-> status_next[BIT_I] && status_next[BIT_F]);

    p_irq_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy && status_load && status_next[4:0] == M_IRQ |-> status_next[BIT_I]);

    p_masked_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !pending |=> !busy);

    p_return_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && ret_req && !pending && banked
        |-> pc_load && status_load && pc_next == link && status_next == saved_status);

    p_unbanked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && ret_req && unbanked |-> !pc_load && !status_load);

endmodule

bind exc_entry exc_entry_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/exc_entry_test.sv
module exc_entry_test;

    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rst_req = 0, dabort = 0, pabort = 0, fiq_n = 1, irq_n = 1;
    logic        swi_dec = 0, undef_dec = 0, ret_req = 0;
    logic [31:0] cur_status = 32'h10, cur_pc = 32'h0;
    logic        busy, status_load, pc_load;
    logic [31:0] status_next, pc_next, saved_status, link;

    int n_checks = 0;
    int n_err    = 0;

    always #(PERIOD/2) clk = ~clk;

    exc_entry uut (
        .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .dabort(dabort),
        .pabort(pabort), .fiq_n(fiq_n), .irq_n(irq_n), .swi_dec(swi_dec),
        .undef_dec(undef_dec), .ret_req(ret_req), .cur_status(cur_status),
        .cur_pc(cur_pc), .busy(busy), .status_load(status_load),
        .status_next(status_next), .pc_load(pc_load), .pc_next(pc_next),
        .saved_status(saved_status), .link(link)
    );

    // request bit order {reset, data abort, fast irq, irq, prefetch abort, swi, undef}
    typedef struct packed {
        logic [6:0]  rq;
        logic [31:0] st;
        logic [31:0] vec;
        logic [31:0] nst;
    } row_t;

    localparam int NROW = 16;
    localparam row_t TBL [NROW] = '{
        '{7'b0000001, 32'h00000010, 32'h04, 32'h0000009B},  // R2 R8 undefined
        '{7'b0000010, 32'h00000010, 32'h08, 32'h00000093},  // R8 swi -> supervisor
        '{7'b0000100, 32'h00000010, 32'h0C, 32'h00000097},  // prefetch abort
        '{7'b0100000, 32'h00000010, 32'h10, 32'h00000097},  // data abort
        '{7'b0001000, 32'hF0000010, 32'h18, 32'hF0000092},  // R4 upper bits kept
        '{7'b0010000, 32'h00000010, 32'h1C, 32'h000000D1},  // R4 fast irq
        '{7'b1000000, 32'h00000010, 32'h00, 32'h000000D3},  // reset
        '{7'b1111110, 32'h00000010, 32'h00, 32'h000000D3},  // R1 all
        '{7'b0111000, 32'h00000010, 32'h10, 32'h00000097},  // R1 R5 dabt over irqs
        '{7'b0011100, 32'h00000010, 32'h1C, 32'h000000D1},  // R1
        '{7'b0001110, 32'h00000010, 32'h18, 32'h00000092},  // R1
        '{7'b0000101, 32'h00000010, 32'h0C, 32'h00000097},  // R1 pabt over undef
        '{7'b0001010, 32'h00000090, 32'h08, 32'h00000093},  // R6 irq masked
        '{7'b0011000, 32'h00000050, 32'h18, 32'h000000D2},  // R6 fiq masked
        '{7'b1000000, 32'h000000D0, 32'h00, 32'h000000D3},  // R7 masks ignored
        '{7'b0000001, 32'h0000003F, 32'h04, 32'h000000BB}   // R4 bit 5 kept
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [6:0] rq);
        {rst_req, dabort} = rq[6:5];
        fiq_n   = !rq[4];
        irq_n   = !rq[3];
        pabort  = rq[2];
        swi_dec = rq[1];
        undef_dec = rq[0];
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    endtask

    // full entry from a negedge; returns at the negedge after the block is idle again
    task automatic run_entry(input string tag, input logic [6:0] rq, input logic [31:0] st,
                             input logic [31:0] pc, input logic [31:0] vec,
                             input logic [31:0] nst);
        @(negedge clk);
        drive(rq); cur_status = st; cur_pc = pc;
        @(posedge clk); @(posedge clk); @(posedge clk);
        @(negedge clk);
        check({tag, " R3 status_load"}, 32'(status_load), 32'd1);
        check({tag, " R4/R8 status_next"}, status_next, nst);
        check({tag, " R3 no early pc_load"}, 32'(pc_load), 32'd0);
        @(negedge clk);
        check({tag, " R3 pc_load"}, 32'(pc_load), 32'd1);
        check({tag, " R1/R2 pc_next"}, pc_next, vec);
        drive(7'b0); cur_status = nst;
        #1;
        check({tag, " R9 saved_status"}, saved_status, st);
        check({tag, " R9 link"}, link, pc);
        @(negedge clk);
        check({tag, " R3 busy low"}, 32'(busy), 32'd0);
    endtask

    initial begin
        #(PERIOD * 100000);
        n_err++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        cur_status = 32'h12;
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state: banks clear, nothing loaded
        check("R9 reset busy", 32'(busy), 32'd0);
        check("R9 reset pc_load", 32'(pc_load), 32'd0);
        check("R9 reset status_load", 32'(status_load), 32'd0);
        check("R9 reset saved", saved_status, 32'd0);
        check("R9 reset link", link, 32'd0);

        for (int i = 0; i < NROW; i++)
            run_entry($sformatf("row %0d", i), TBL[i].rq, TBL[i].st,
                      32'h100 + 32'(i) * 32'h10, TBL[i].vec, TBL[i].nst);

        // R6: both interrupts masked, no entry
        @(negedge clk);
        cur_status = 32'hD0; drive(7'b0011000);
        repeat (3) begin
            @(negedge clk);
            check("R6 masked no busy", 32'(busy), 32'd0);
        end
        drive(7'b0);

        // R5: data abort keeps fast irq open, fast irq nests on top
        run_entry("R5 dabt", 7'b0100000, 32'h10, 32'h500, 32'h10, 32'h97);
        run_entry("R5 nested fiq", 7'b0010000, 32'h97, 32'h504, 32'h1C, 32'hD1);

        // R10: return from an irq entry
        run_entry("R10 irq", 7'b0001000, 32'h30, 32'h2468, 32'h18, 32'hB2);
        @(negedge clk);
        ret_req = 1'b1;
        #(PERIOD/4);
        check("R10 ret pc_load", 32'(pc_load), 32'd1);
        check("R10 ret pc_next", pc_next, 32'h2468);
        check("R10 ret status_load", 32'(status_load), 32'd1);
        check("R10 ret status_next", status_next, 32'h30);
        @(negedge clk);
        ret_req = 1'b0;
        check("R10 ret stays idle", 32'(busy), 32'd0);

        // R11: return while a swi wins arbitration
        @(negedge clk);
        ret_req = 1'b1; swi_dec = 1'b1;
        #(PERIOD/4);
        check("R11 pending no pc_load", 32'(pc_load), 32'd0);
        check("R11 pending no status_load", 32'(status_load), 32'd0);
        @(negedge clk);
        ret_req = 1'b0; swi_dec = 1'b0;
        check("R11 swi entered", 32'(busy), 32'd1);
        repeat (4) @(negedge clk);
        check("R11 swi done", 32'(busy), 32'd0);

        // R11 / R9: unbanked modes
        cur_status = 32'h1F;
        ret_req = 1'b1;
        #(PERIOD/4);
        check("R11 system mode no pc_load", 32'(pc_load), 32'd0);
        check("R11 system mode no status_load", 32'(status_load), 32'd0);
        check("R9 system mode saved zero", saved_status, 32'd0);
        @(negedge clk);
        cur_status = 32'h10;
        #(PERIOD/4);
        check("R11 user mode no pc_load", 32'(pc_load), 32'd0);
        check("R9 user mode link zero", link, 32'd0);
        @(negedge clk);
        ret_req = 1'b0;
        check("R11 user mode idle", 32'(busy), 32'd0);

        finish_run();
    end

endmodule